// File: doc/BRIEF.md
# Dual Four-Mode Up-Counter Timer

This block holds two identical up-counting timers, each kept in a low byte and a high byte. A two-bit mode input per timer picks one of four counting arrangements: a 13-bit counter where five low-byte bits prescale into the high byte, a full 16-bit counter, an 8-bit counter that reloads itself from the high byte, and a split arrangement in which timer 0 becomes two free 8-bit counters while timer 1 stands still. Every arrangement counts upward and wraps from all ones to all zeros, and each wrap raises a sticky overflow flag.

Each timer advances either on a one-cycle internal tick or on falling edges of an external count pin. The pin is resynchronised inside the block. Counting is allowed only when the timer's run input is high. When the timer's gate mode is selected, the timer's gate pin must also be high. The four bytes can be written and read through a small address port. Software clears the flags with a per-timer clear input.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset, all four bytes read zero and both overflow flags are low.
- R2: In mode 1 the timer is a 16-bit count {high, low}. It steps by one per enabled event, and its wrap from 16'hFFFF to 16'h0000 raises the timer's flag.
- R3: In mode 0 the timer is a 13-bit count {high, low[4:0]}. The bits low[7:5] keep their value, and the wrap from all ones to zero raises the flag.
- R4: In mode 2 the low byte steps by one. When it is 8'hFF, the next event loads it from the high byte and raises the flag, and the high byte does not change.
- R5: With timer 0 in mode 3, the low byte of timer 0 is an 8-bit counter that uses timer 0's enable and source and sets flag 0. The high byte of timer 0 is an 8-bit counter that steps on each cycle where run[1] and tick are both high, and its wrap sets flag 1. Wraps of timer 1 itself do not set flag 1 during this time.
- R6: Timer 1 in mode 3 holds both of its bytes.
- R7: A timer may count only while run AND (NOT gate_en OR gate_pin) is true. The gate pin is taken as a synchronous input.
- R8: With ext_sel high, the timer steps once per falling edge of its cnt_pin. The pin passes through two synchronising flops, and the count changes at the third rising clock edge after the first edge that samples the pin low.
- R9: Byte write addresses: wr_addr[1] selects the timer and wr_addr[0] selects the high byte (0: timer 0 low, 1: timer 0 high, 2: timer 1 low, 3: timer 1 high). A write replaces the byte at the next edge. In that cycle it stops all counting of the timer that owns the byte and prevents that timer from raising a flag. rd_data shows the byte at rd_addr without delay.
- R10: A flag stays set until its ovf_clr bit is high at a clock edge. If the flag is set and cleared in the same cycle, setting wins.
- R11: With ext_sel low, the timer steps once for each cycle in which tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Internal count pulse, one cycle wide |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte select for writes |
| wr_data | input | BYTE_W | Write data |
| rd_addr | input | 2 | Byte select for reads |
| rd_data | output | BYTE_W | Selected byte |
| mode0 | input | 2 | Timer 0 mode |
| mode1 | input | 2 | Timer 1 mode |
| run | input | 2 | Per-timer run enable |
| gate_en | input | 2 | Per-timer gate-mode select |
| gate_pin | input | 2 | Per-timer gate pin |
| ext_sel | input | 2 | Per-timer source: 1 selects cnt_pin |
| cnt_pin | input | 2 | Per-timer external count pin |
| ovf_clr | input | 2 | Per-timer flag clear |
| ovf | output | 2 | Per-timer overflow flag |

## Verification
The bench builds the block with its default values: 8-bit bytes, a 5-bit prescaler field and two synchronising stages. With these values, preloading a byte near all ones reaches every wrap (13-bit, 16-bit, 8-bit reload and both split halves) within a few dozen cycles. The two-stage value fixes the pin-to-count latency of three edges, and the cycle-accurate reference model follows that latency. Long random runs then mix mode changes, writes, clears and pin activity against the same model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W_D  = 8;
    localparam int PRE_W_D   = 5;
    localparam int SYNC_D    = 2;
    localparam int NUM_TMR   = 2;

    typedef enum logic [1:0] {
        M_PRESC  = 2'd0,
        M_WIDE   = 2'd1,
        M_RELOAD = 2'd2,
        M_SPLIT  = 2'd3
    } tmode_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } tpair_s;

    function automatic logic gate_ok(input logic run_i, input logic gmode_i, input logic gpin_i);
        return run_i & (~gmode_i | gpin_i);
    endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W        = 8,
    parameter int PW       = 5,
    parameter bit SPLIT_OK = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  tmode_e       mode,
    input  tpair_s       step,
    input  tpair_s       wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q,
    output tpair_s       wrap
);
    logic [W-1:0] lo_n, hi_n;

    always_comb begin
        lo_n = lo_q;
        hi_n = hi_q;
        wrap = '0;
        if (wr.lo || wr.hi) begin
            if (wr.lo) lo_n = wdata;
            if (wr.hi) hi_n = wdata;
        end else begin
            unique case (mode)
                M_PRESC: if (step.lo) begin
                    if (&lo_q[PW-1:0]) begin
                        lo_n[PW-1:0] = '0;
                        hi_n         = hi_q + W'(1);
                        wrap.lo      = &hi_q;
                    end else begin
                        lo_n[PW-1:0] = lo_q[PW-1:0] + PW'(1);
                    end
                end
                M_WIDE: if (step.lo) begin
                    {hi_n, lo_n} = {hi_q, lo_q} + (2*W)'(1);
                    wrap.lo      = &{hi_q, lo_q};
                end
                M_RELOAD: if (step.lo) begin
                    if (&lo_q) begin
                        lo_n    = hi_q;
                        wrap.lo = 1'b1;
                    end else begin
                        lo_n = lo_q + W'(1);
                    end
                end
                M_SPLIT: if (SPLIT_OK) begin
                    if (step.lo) begin
                        lo_n    = lo_q + W'(1);
                        wrap.lo = &lo_q;
                    end
                    if (step.hi) begin
                        hi_n    = hi_q + W'(1);
                        wrap.hi = &hi_q;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BYTE_W      = BYTE_W_D,
    parameter int PRE_W       = PRE_W_D,
    parameter int SYNC_STAGES = SYNC_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [1:0]        mode0,
    input  logic [1:0]        mode1,
    input  logic [1:0]        run,
    input  logic [1:0]        gate_en,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        ext_sel,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        ovf_clr,
    output logic [1:0]        ovf
);
    logic [NUM_TMR-1:0][BYTE_W-1:0] lo_q, hi_q;
    tmode_e  mode_v [NUM_TMR];
    tpair_s  step_v [NUM_TMR];
    tpair_s  wr_v   [NUM_TMR];
    tpair_s  wrap_v [NUM_TMR];
    logic [NUM_TMR-1:0] fall, en;
    logic [1:0] ovf_set;
    logic [1:0] ovf_q;

    assign mode_v[0] = tmode_e'(mode0);
    assign mode_v[1] = tmode_e'(mode1);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .pin  (cnt_pin[i]),
            .fall (fall[i])
        );

        assign en[i]         = gate_ok(run[i], gate_en[i], gate_pin[i]);
        assign step_v[i].lo  = en[i] & (ext_sel[i] ? fall[i] : tick);
        if (i == 0) begin : g_hi_src
            assign step_v[i].hi = run[1] & tick;
        end else begin : g_hi_none
            assign step_v[i].hi = 1'b0;
        end
        assign wr_v[i].lo = wr_en & (wr_addr[1] == 1'(i)) & ~wr_addr[0];
        assign wr_v[i].hi = wr_en & (wr_addr[1] == 1'(i)) &  wr_addr[0];

        tmr_core #(.W(BYTE_W), .PW(PRE_W), .SPLIT_OK(i == 0)) u_core (
            .clk   (clk),
            .rst   (rst),
            .mode  (mode_v[i]),
            .step  (step_v[i]),
            .wr    (wr_v[i]),
            .wdata (wr_data),
            .lo_q  (lo_q[i]),
            .hi_q  (hi_q[i]),
            .wrap  (wrap_v[i])
        );
    end

    // Split mode hands flag 1 to the high byte of timer 0.
    assign ovf_set[0] = wrap_v[0].lo;
    assign ovf_set[1] = (mode_v[0] == M_SPLIT) ? wrap_v[0].hi
                                               : (wrap_v[1].lo | wrap_v[1].hi);

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= '0;
        else     ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
    end

    assign ovf = ovf_q;

    always_comb begin
        unique case (rd_addr)
            2'd0:    rd_data = lo_q[0];
            2'd1:    rd_data = hi_q[0];
            2'd2:    rd_data = lo_q[1];
            default: rd_data = hi_q[1];
        endcase
    end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic                    wr_en,
    input logic [1:0]              wr_addr,
    input logic [BYTE_W-1:0]       wr_data,
    input logic [1:0]              mode0,
    input logic [1:0]              mode1,
    input logic [1:0]              run,
    input logic [1:0]              gate_en,
    input logic [1:0]              gate_pin,
    input logic [1:0]              ext_sel,
    input logic [1:0]              ovf_clr,
    input logic [1:0]              ovf,
    input logic [1:0][BYTE_W-1:0]  lo_q,
    input logic [1:0][BYTE_W-1:0]  hi_q
);
    logic wr_t0, wr_t1;
    assign wr_t0 = wr_en & ~wr_addr[1];
    assign wr_t1 = wr_en &  wr_addr[1];

    p_write_low0_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> lo_q[0] == $past(wr_data));

    p_t1_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mode1 == 2'd3 && !wr_t1) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf[0] && !ovf_clr[0]) |=> ovf[0]);

    p_no_enable_r7: assert property (@(posedge clk) disable iff (rst)
        (!(run[0] && (!gate_en[0] || gate_pin[0])) && !wr_t0) |=> $stable(lo_q[0]));

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (mode0 == 2'd2 && run[0] && !gate_en[0] && !ext_sel[0] && tick &&
         lo_q[0] == '1 && !wr_t0) |=> (lo_q[0] == $past(hi_q[0]) && ovf[0]));

    p_split_hi_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (mode0 == 2'd3 && !(run[1] && tick) && !wr_t0) |=> $stable(hi_q[0]));

    p_presc_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (mode0 == 2'd0 && !wr_t0) |=> lo_q[0][BYTE_W-1:5] == $past(lo_q[0][BYTE_W-1:5]));
endmodule

bind tmr_pair tmr_pair_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode0    (mode0),
    .mode1    (mode1),
    .run      (run),
    .gate_en  (gate_en),
    .gate_pin (gate_pin),
    .ext_sel  (ext_sel),
    .ovf_clr  (ovf_clr),
    .ovf      (ovf),
    .lo_q     (lo_q),
    .hi_q     (hi_q)
);

// File: tb/tmr_pair_bench.sv
`timescale 1ns/1ps
module tmr_pair_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] mode0 = '0, mode1 = '0, run = '0, gate_en = '0;
    logic [1:0] gate_pin = '0, ext_sel = '0, cnt_pin = '0, ovf_clr = '0;
    logic [1:0] ovf;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit rnd_pins = 0;
    bit rnd_tick = 0;

    always #2.5 clk = ~clk;

    tmr_pair u_tmr_pair (.*);

    // ---------------- reference model ----------------
    int  m_lo [2];
    int  m_hi [2];
    bit  m_ovf [2];
    bit  h0 [$];
    bit  h1 [$];

    task automatic std_step(input int md, input bit s, inout int lo, inout int hi, output bit ov);
        int v;
        ov = 0;
        if (!s) return;
        case (md)
            0: begin
                v = hi * 32 + (lo % 32) + 1;
                if (v == 8192) begin v = 0; ov = 1; end
                hi = v / 32;
                lo = (lo & 224) | (v % 32);
            end
            1: begin
                v = hi * 256 + lo + 1;
                if (v == 65536) begin v = 0; ov = 1; end
                hi = v / 256;
                lo = v % 256;
            end
            2: begin
                if (lo == 255) begin lo = hi; ov = 1; end
                else lo = lo + 1;
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        bit f0, f1, s0, s1, set0, set1, set1b, w0, w1;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_ovf[i] = 0; end
            h0 = '{0, 0, 0};
            h1 = '{0, 0, 0};
        end else begin
            f0 = h0[0] && !h0[1];
            f1 = h1[0] && !h1[1];
            s0 = run[0] && (!gate_en[0] || gate_pin[0]) && (ext_sel[0] ? f0 : tick);
            s1 = run[1] && (!gate_en[1] || gate_pin[1]) && (ext_sel[1] ? f1 : tick);
            w0 = wr_en && !wr_addr[1];
            w1 = wr_en &&  wr_addr[1];
            set0 = 0; set1 = 0; set1b = 0;
            if (w0) begin
                if (wr_addr[0]) m_hi[0] = wr_data; else m_lo[0] = wr_data;
            end else if (mode0 == 3) begin
                if (s0) begin m_lo[0] = (m_lo[0] + 1) % 256; set0 = (m_lo[0] == 0); end
                if (run[1] && tick) begin m_hi[0] = (m_hi[0] + 1) % 256; set1 = (m_hi[0] == 0); end
            end else begin
                std_step(mode0, s0, m_lo[0], m_hi[0], set0);
            end
            if (w1) begin
                if (wr_addr[0]) m_hi[1] = wr_data; else m_lo[1] = wr_data;
            end else begin
                std_step(mode1, s1, m_lo[1], m_hi[1], set1b);
            end
            if (mode0 != 3) set1 = set1b;
            m_ovf[0] = (m_ovf[0] && !ovf_clr[0]) || set0;
            m_ovf[1] = (m_ovf[1] && !ovf_clr[1]) || set1;
            h0.push_back(cnt_pin[0]); void'(h0.pop_front());
            h1.push_back(cnt_pin[1]); void'(h1.pop_front());
        end
    end

    // ---------------- checking and driving ----------------
    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        int exp_b;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            case (rd_addr)
                2'd0: exp_b = m_lo[0];
                2'd1: exp_b = m_hi[0];
                2'd2: exp_b = m_lo[1];
                default: exp_b = m_hi[1];
            endcase
            chk($sformatf("byte %0d", rd_addr), rd_data, exp_b);
            chk("flags", ovf, {m_ovf[1], m_ovf[0]});
            rd_addr = rd_addr + 2'd1;
            if (rnd_pins) begin
                cnt_pin  = 2'($urandom);
                gate_pin = 2'($urandom);
            end
            if (rnd_tick) tick = 1'($urandom);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 0;
    endtask

    task automatic clr_flags();
        ovf_clr = 2'b11;
        cyc(1);
        ovf_clr = 2'b00;
    endtask

    initial begin
        cyc(3);
        rst = 0;
        cur_req = "R1 reset state";
        cyc(4);

        cur_req = "R9 byte writes";
        wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd2, 8'h33); wr(2'd3, 8'h44);
        cyc(8);

        cur_req = "R2 16-bit rollover";
        mode0 = 2'd1; tick = 1;
        wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
        run[0] = 1;
        cyc(24);

        cur_req = "R9 write during counting";
        wr(2'd0, 8'h05);
        cyc(4);

        cur_req = "R3 13-bit prescaled";
        mode1 = 2'd0;
        wr(2'd2, 8'hFE); wr(2'd3, 8'hFF);
        run[1] = 1;
        cyc(40);

        cur_req = "R10 flag clear";
        clr_flags();
        cyc(4);

        cur_req = "R4 8-bit reload";
        mode0 = 2'd2;
        wr(2'd1, 8'h80); wr(2'd0, 8'hFA);
        cyc(300);
        clr_flags();

        cur_req = "R5 split timer 0";
        mode0 = 2'd3; mode1 = 2'd1;
        wr(2'd0, 8'hF0); wr(2'd1, 8'hF8); wr(2'd2, 8'hF0); wr(2'd3, 8'hFF);
        cyc(40);
        run[1] = 0;
        cyc(10);
        run[1] = 1;
        clr_flags();
        cyc(20);

        cur_req = "R6 timer 1 held";
        mode0 = 2'd1; mode1 = 2'd3;
        cyc(30);

        cur_req = "R7 gate";
        mode1 = 2'd1; gate_en = 2'b11; rnd_pins = 1;
        cyc(200);
        run = 2'b00;
        cyc(20);
        run = 2'b11;

        cur_req = "R8 external pin";
        gate_en = 2'b00; ext_sel = 2'b11;
        cyc(400);

        cur_req = "R11 internal tick";
        ext_sel = 2'b00; rnd_tick = 1;
        cyc(200);

        cur_req = "R10 set beats clear";
        rnd_tick = 0; tick = 1; mode0 = 2'd2;
        wr(2'd1, 8'hFE); wr(2'd0, 8'hFE);
        ovf_clr = 2'b11;
        cyc(6);
        ovf_clr = 2'b00;

        cur_req = "mix R2 R3 R4 R5 R7 R8";
        rnd_tick = 1;
        for (int k = 0; k < 3000; k++) begin
            if ($urandom % 50 == 0) mode0 = 2'($urandom);
            if ($urandom % 50 == 0) mode1 = 2'($urandom);
            if ($urandom % 40 == 0) begin run = 2'($urandom); gate_en = 2'($urandom); ext_sel = 2'($urandom); end
            ovf_clr = ($urandom % 20 == 0) ? 2'($urandom) : 2'b00;
            if ($urandom % 30 == 0) wr(2'($urandom), 8'($urandom | 8'hE0));
            else cyc(1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule